// File: doc/BRIEF.md
# Self-Clocked Serial Converter Frame Receiver

This block sits on the host side of a link to a converter that drives both the serial clock and the serial data pins itself. It brings the two raw pins into the system clock domain, follows the converter's signalling (both pins high while a conversion runs, both pins low when a result is ready), then samples the data pin on each rising serial-clock edge until a 24-bit frame is complete. The frame is split into a 20-bit magnitude field, a sign flag and an extended-range flag, and is presented with a one-cycle strobe.

A frame whose first bit shows that the conversion had not finished is rejected with a one-cycle error strobe. A frame that stalls mid-way for longer than a set number of system cycles is rejected the same way. In both cases the receiver goes back to waiting for the next conversion. The data path is a stream that cannot be held back: the converter pushes each frame on its own clock and has no way to pause. For that reason the output has no ready input. The consumer must take the result in the cycle the strobe is high. The result fields hold their value until the next accepted frame.

Top module: `adc_frame_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid`, `frame_err`, `res_data`, `res_sign` and `res_ext` are all 0.
- R2: Rising edges on `sck_pin` produce neither `res_valid` nor `frame_err` unless both pins have first been seen high together and then low together.
- R3: After the arm condition (both pins low following both high), the first rising SCK edge samples frame bit 23 (the completion flag). Each later rising edge samples the next lower bit, so the frame is sent most-significant bit first.
- R4: A frame is exactly 24 samples. Bit 21 drives `res_sign`, bit 20 drives `res_ext`, bits 19..0 drive `res_data`, and bit 22 has no effect on any output.
- R5: For a frame whose bit 23 is 0, `res_valid` is high for exactly one cycle. It rises 4 system cycles after the 24th rising SCK edge appears on the pin (that is, SYNC_STAGES+2).
- R6: A frame whose bit 23 is 1 gives a one-cycle `frame_err` with the same latency as R5, gives no `res_valid`, and leaves `res_data`, `res_sign` and `res_ext` unchanged.
- R7: While capturing, if TIMEOUT_CYC system cycles pass with no rising SCK edge, `frame_err` pulses once and the partial frame is dropped. A following complete frame decodes normally. Gaps shorter than the limit cause no error.
- R8: `res_valid` and `frame_err` are never high in the same cycle, and the result fields change only in a cycle where `res_valid` is high.
- R9: After a frame ends, the receiver does not re-arm until both pins have been high together (a new conversion), so further SCK pulses with SDO held low produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_pin | input | 1 | Raw serial clock driven by the converter |
| sdo_pin | input | 1 | Raw serial data driven by the converter |
| res_valid | output | 1 | One-cycle strobe: a new result is on the result fields |
| res_data | output | RES_BITS (20) | Magnitude field of the last good frame |
| res_sign | output | 1 | Sign flag of the last good frame |
| res_ext | output | 1 | Extended-range flag of the last good frame |
| frame_err | output | 1 | One-cycle strobe: a frame was rejected (completion flag set or stall) |

## Verification
The assertions assume that the converter follows its own protocol. That means SCK pulses last at least a few system cycles, so each rising edge is seen once after synchronization, and no two frames can finish within two cycles of each other. The bench drives each SCK half-period for at least four system cycles and starts a new frame only after a conversion phase with both pins high. The only stall it creates is the deliberate one that tests the timeout. SDO is changed only while SCK is low, so it is stable at every rising edge the receiver samples.

// File: rtl/adc_rx_pkg.sv
`timescale 1ns/1ps
package adc_rx_pkg;

  // Receiver sequencing: look for a conversion, wait for its end, shift bits.
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,  // waiting for both pins high (conversion running)
    RX_CONV = 2'd1,  // conversion running, waiting for both pins low
    RX_CAPT = 2'd2   // armed, sampling SDO on rising SCK
  } rx_state_e;

  // Number of bits needed to count 0..n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
`timescale 1ns/1ps
module adc_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_s
);

  // Flop chain per pin; the last stage is the only one other logic may use.
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= pins;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign pins_s = chain[STAGES-1];

endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_rx_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int RES_BITS    = 20,
  parameter int TIMEOUT_CYC = 4096,
  localparam int CW = cnt_width(FRAME_BITS),
  localparam int TW = cnt_width(TIMEOUT_CYC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_s,
  input  logic                sdo_s,
  output logic                sck_rise,
  output logic                capturing,
  output logic [CW-1:0]       bit_cnt,
  output logic                frame_done,
  output logic                stall_err,
  output logic                word_eoc,
  output logic                word_sign,
  output logic                word_ext,
  output logic [RES_BITS-1:0] word_data
);

  localparam int EOC_POS  = FRAME_BITS - 1;
  localparam int SIGN_POS = RES_BITS + 1;
  localparam int EXT_POS  = RES_BITS;

  rx_state_e             state;
  logic                  sck_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [TW-1:0]         idle_cnt;

  assign sck_rise  = sck_s & ~sck_q;
  assign capturing = (state == RX_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_HUNT;
      sck_q      <= 1'b0;
      shreg      <= '0;
      bit_cnt    <= '0;
      idle_cnt   <= '0;
      frame_done <= 1'b0;
      stall_err  <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      frame_done <= 1'b0;
      stall_err  <= 1'b0;
      unique case (state)
        RX_HUNT: begin
          if (sck_s && sdo_s) state <= RX_CONV;
        end
        RX_CONV: begin
          if (!sck_s && !sdo_s) begin
            state    <= RX_CAPT;
            bit_cnt  <= '0;
            idle_cnt <= '0;
          end
        end
        RX_CAPT: begin
          if (sck_rise) begin
            shreg    <= {shreg[FRAME_BITS-2:0], sdo_s};
            idle_cnt <= '0;
            if (bit_cnt == CW'(FRAME_BITS - 1)) begin
              frame_done <= 1'b1;
              bit_cnt    <= '0;
              state      <= RX_HUNT;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end else if (idle_cnt == TW'(TIMEOUT_CYC - 1)) begin
            stall_err <= 1'b1;
            bit_cnt   <= '0;
            state     <= RX_HUNT;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  assign word_eoc  = shreg[EOC_POS];
  assign word_sign = shreg[SIGN_POS];
  assign word_ext  = shreg[EXT_POS];
  assign word_data = shreg[RES_BITS-1:0];

endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
module adc_result_reg #(
  parameter int RES_BITS = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_done,
  input  logic                stall_err,
  input  logic                word_eoc,
  input  logic                word_sign,
  input  logic                word_ext,
  input  logic [RES_BITS-1:0] word_data,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_sign,
  output logic                res_ext,
  output logic                frame_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      frame_err <= 1'b0;
      res_data  <= '0;
      res_sign  <= 1'b0;
      res_ext   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      frame_err <= 1'b0;
      if (frame_done) begin
        if (word_eoc) begin
          frame_err <= 1'b1;
        end else begin
          res_valid <= 1'b1;
          res_data  <= word_data;
          res_sign  <= word_sign;
          res_ext   <= word_ext;
        end
      end else if (stall_err) begin
        frame_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_frame_rx.sv
`timescale 1ns/1ps
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int RES_BITS    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 4096,
  localparam int CW = cnt_width(FRAME_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_pin,
  input  logic                sdo_pin,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_sign,
  output logic                res_ext,
  output logic                frame_err
);

  logic [1:0]          pins_s;
  logic                sck_rise;
  logic                capturing;
  logic [CW-1:0]       bit_cnt;
  logic                frame_done;
  logic                stall_err;
  logic                word_eoc;
  logic                word_sign;
  logic                word_ext;
  logic [RES_BITS-1:0] word_data;

  adc_pin_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pins  ({sdo_pin, sck_pin}),
    .pins_s(pins_s)
  );

  adc_frame_seq #(
    .FRAME_BITS (FRAME_BITS),
    .RES_BITS   (RES_BITS),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (pins_s[0]),
    .sdo_s     (pins_s[1]),
    .sck_rise  (sck_rise),
    .capturing (capturing),
    .bit_cnt   (bit_cnt),
    .frame_done(frame_done),
    .stall_err (stall_err),
    .word_eoc  (word_eoc),
    .word_sign (word_sign),
    .word_ext  (word_ext),
    .word_data (word_data)
  );

  adc_result_reg #(
    .RES_BITS(RES_BITS)
  ) u_res (
    .clk       (clk),
    .rst       (rst),
    .frame_done(frame_done),
    .stall_err (stall_err),
    .word_eoc  (word_eoc),
    .word_sign (word_sign),
    .word_ext  (word_ext),
    .word_data (word_data),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_sign  (res_sign),
    .res_ext   (res_ext),
    .frame_err (frame_err)
  );

endmodule

// File: rtl/adc_frame_rx_chk.sv
`timescale 1ns/1ps
module adc_frame_rx_chk
  import adc_rx_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int RES_BITS    = 20,
  parameter int TIMEOUT_CYC = 4096,
  localparam int CW = cnt_width(FRAME_BITS),
  localparam int TW = cnt_width(TIMEOUT_CYC)
) (
  input logic                clk,
  input logic                rst,
  input logic                res_valid,
  input logic                frame_err,
  input logic [RES_BITS-1:0] res_data,
  input logic                res_sign,
  input logic                res_ext,
  input logic                capturing,
  input logic                sck_rise,
  input logic [CW-1:0]       bit_cnt
);

  // Independent count of capture cycles without a rising SCK edge.
  logic [TW:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (rst || !capturing || sck_rise) gap_cnt <= '0;
    else                               gap_cnt <= gap_cnt + 1'b1;
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && frame_err));

  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ({res_sign, res_ext, res_data} != $past({res_sign, res_ext, res_data})) |-> res_valid);

  assert_bit_range_R4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(FRAME_BITS - 1));

  assert_stall_bound_R7: assert property (@(posedge clk) disable iff (rst)
    capturing |-> (gap_cnt < (TW+1)'(TIMEOUT_CYC)));

endmodule

bind adc_frame_rx adc_frame_rx_chk #(
  .FRAME_BITS (FRAME_BITS),
  .RES_BITS   (RES_BITS),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .res_valid(res_valid),
  .frame_err(frame_err),
  .res_data (res_data),
  .res_sign (res_sign),
  .res_ext  (res_ext),
  .capturing(capturing),
  .sck_rise (sck_rise),
  .bit_cnt  (bit_cnt)
);

// File: tb/sim_adc_frame_rx.sv
`timescale 1ns/1ps
module sim_adc_frame_rx;

  localparam int RB   = 20;
  localparam int TMO  = 64;
  localparam int LAT  = 4;   // SYNC_STAGES + 2 with default sync depth

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sck_pin = 1'b1;
  logic          sdo_pin = 1'b1;
  logic          res_valid;
  logic [RB-1:0] res_data;
  logic          res_sign;
  logic          res_ext;
  logic          frame_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int vcount = 0, ecount = 0, vcyc = 0, ecyc = 0, rise_cyc = 0;
  logic [RB-1:0] vdata = '0;
  logic          vsign = 1'b0, vext = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_frame_rx #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .sck_pin(sck_pin), .sdo_pin(sdo_pin),
    .res_valid(res_valid), .res_data(res_data), .res_sign(res_sign),
    .res_ext(res_ext), .frame_err(frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      vcount++; vcyc = cyc; vdata = res_data; vsign = res_sign; vext = res_ext;
    end
    if (!rst && frame_err) begin
      ecount++; ecyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Conversion phase, end-of-conversion handshake, then nbits MSB-first bits.
  task automatic send_frame(input logic [23:0] w, input int hb, input int nbits, input bit tail_hi);
    sck_pin = 1'b1; sdo_pin = 1'b1; waitc(8);
    sck_pin = 1'b0; sdo_pin = 1'b0; waitc(4);
    for (int i = 0; i < nbits; i++) begin
      sck_pin = 1'b0; sdo_pin = w[23-i]; waitc(hb);
      sck_pin = 1'b1;
      if (i == 23) rise_cyc = cyc;
      waitc(hb);
    end
    if (tail_hi) sdo_pin = 1'b1;
  endtask

  task automatic good_frame(input logic [23:0] w, input int hb, input bit tail_hi);
    int v0, e0;
    v0 = vcount; e0 = ecount;
    send_frame(w, hb, 24, tail_hi);
    waitc(10);
    chk(vcount == v0 + 1, "R5 one valid per frame", vcount - v0, 1);
    chk(ecount == e0, "R8 no error on good frame", ecount - e0, 0);
    chk(vcyc - rise_cyc == LAT, "R5 valid latency", vcyc - rise_cyc, LAT);
    chk(vdata == w[RB-1:0], "R3 R4 data field", vdata, w[RB-1:0]);
    chk(vsign == w[21], "R4 sign flag", vsign, w[21]);
    chk(vext == w[20], "R4 ext flag", vext, w[20]);
    chk(res_data == w[RB-1:0], "R8 data held", res_data, w[RB-1:0]);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] pats [6];
    int v0, e0;
    pats[0] = 24'h0FFFFF; pats[1] = 24'h3FFFFF; pats[2] = 24'h2ABCDE;
    pats[3] = 24'h155555; pats[4] = 24'h000000; pats[5] = 24'h7C0F0F;

    // R1: reset state
    waitc(5);
    chk(res_valid == 0 && frame_err == 0, "R1 strobes in reset", {res_valid, frame_err}, 0);
    chk(res_data == 0 && res_sign == 0 && res_ext == 0, "R1 fields in reset", res_data, 0);
    rst = 1'b0;
    waitc(1);
    chk(res_valid == 0 && frame_err == 0 && res_data == 0, "R1 after reset", res_data, 0);

    // R2: SCK toggles with SDO high never arm
    for (int i = 0; i < 30; i++) begin
      sck_pin = 1'b0; waitc(3); sck_pin = 1'b1; waitc(3);
    end
    waitc(10);
    chk(vcount == 0 && ecount == 0, "R2 no output while unarmed", vcount + ecount, 0);

    // R3 R4 R5: walking one through bits 22..0
    for (int k = 0; k < 23; k++) good_frame(24'(1) << k, 4, 1'b1);
    for (int p = 0; p < 6; p++) good_frame(pats[p], 4, 1'b1);

    // R7: slow SCK within the stall limit still decodes
    good_frame(24'h1A5A5A, 20, 1'b1);

    // R6: completion flag set rejects frame
    v0 = vcount; e0 = ecount;
    send_frame(24'h812345, 4, 24, 1'b1);
    waitc(10);
    chk(ecount == e0 + 1, "R6 error on flag set", ecount - e0, 1);
    chk(vcount == v0, "R6 no valid on flag set", vcount - v0, 0);
    chk(ecyc - rise_cyc == LAT, "R6 error latency", ecyc - rise_cyc, LAT);
    chk(res_data == 20'h1A5A5 << 0 ? 1'b1 : res_data == 20'hA5A5A, "R6 data unchanged", res_data, 20'hA5A5A);
    chk(res_sign == 1'b0 && res_ext == 1'b1, "R6 flags unchanged", {res_sign, res_ext}, 2'b01);

    // R7: stall mid-frame
    v0 = vcount; e0 = ecount;
    send_frame(24'h0F0F0F, 4, 10, 1'b0);
    sck_pin = 1'b0;
    waitc(TMO + 20);
    chk(ecount == e0 + 1, "R7 stall error", ecount - e0, 1);
    chk(vcount == v0, "R7 stalled frame dropped", vcount - v0, 0);
    good_frame(24'h2C3D4E, 4, 1'b1);

    // R9: no re-arm without a conversion phase
    good_frame(24'h012340, 4, 1'b0);
    v0 = vcount; e0 = ecount;
    sck_pin = 1'b0; sdo_pin = 1'b0; waitc(6);
    for (int i = 0; i < 24; i++) begin
      sck_pin = 1'b0; waitc(4); sck_pin = 1'b1; waitc(4);
    end
    waitc(TMO + 20);
    chk(vcount == v0 && ecount == e0, "R9 no re-arm", (vcount - v0) + (ecount - e0), 0);
    chk(res_data == 20'h12340, "R9 result unchanged", res_data, 20'h12340);
    good_frame(24'h3FFFFE, 4, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule